// File: doc/BRIEF.md
# Fill-Order Stack Victim Selector

This block chooses which way of one eight-way cache set should be replaced. It keeps, for every way, a position in a stack ordered by when the way was filled: the newest fill sits at position 0 (the top), the oldest at the largest position (the bottom). Each way also carries a flag that says whether the block has been hit since it arrived at its current position. A knee input divides the stack: positions strictly smaller than the knee count as "above the knee". When a victim is requested, the selector returns the way that is nearest the top, above the knee, and still unhit at its position. If no way qualifies, it returns the bottom of the stack.

A small pseudo-random generator lets blocks escape. When its value does not exceed a programmable threshold, the above-knee search is skipped and the bottom block is evicted instead, so the unhit block near the top survives past the knee. The controller has two states. `ST_WARM` is entered at reset and lasts while any way is empty; in it the lowest-numbered empty way is always the victim. `ST_FULL` is entered through the transition `T_SET_FULL`, which fires on the fill that occupies the last empty way. `ST_FULL` has no exit other than reset. In `ST_FULL` the knee, flag and escape rules apply. The victim is combinational, so it is valid in the same cycle as the request.

Top module: `fill_stack_victim_sel`

## Requirements
- R1: After reset every way is empty, and a request returns way 0.
- R2: While any way is empty, a request returns the lowest-numbered empty way.
- R3: A fill places its way at position 0 with a clear hit flag. Valid ways above the filled way's old position move down by one position; if the way was empty, every valid way moves down. Ways below its old position keep their position and flag.
- R4: A way that moves down because of a fill has its hit flag cleared.
- R5: A hit to a valid way, with no fill to that way in the same cycle, sets that way's hit flag. The way keeps its position.
- R6: When the set is full and no escape occurs, the victim is the way with the smallest position below the knee whose hit flag is clear.
- R7: When the set is full and no way below the knee has a clear flag, the victim is the way at position 7 (the bottom).
- R8: A knee value of 0 makes every full-set victim the bottom way.
- R9: Escape occurs when the 16-bit generator value is less than or equal to `escape_thresh`, and it makes the victim the bottom way. The generator value is never 0, so a threshold of 0 never escapes and a threshold of 16'hFFFF always escapes.
- R10: `victim_valid` equals `victim_req` in the same cycle, and `victim_way` is valid in that cycle without any clock delay.
- R11: When a fill and a hit target the same way in one cycle, the fill wins and the way's hit flag ends clear.
- R12: Once all eight ways are valid, they stay valid until reset, and no request falls back to the empty-way rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A block is being written into `fill_way` |
| fill_way | input | 3 | Way receiving the fill |
| hit_valid | input | 1 | A lookup hit `hit_way` |
| hit_way | input | 3 | Way that was hit |
| victim_req | input | 1 | Replacement decision wanted this cycle |
| knee | input | 3 | Positions below this value count as above the knee |
| escape_thresh | input | 16 | Escape when the generator value is at most this |
| victim_valid | output | 1 | `victim_way` is meaningful |
| victim_way | output | 3 | Selected way |

## Verification
The bound checker checks the following on every cycle:
- Stack positions stay distinct among valid ways.
- A fill lands at the top.
- A hit raises its flag, unless a fill to the same way overrides it.
- A full set never loses a way.
- Every full-set victim is either an unhit way below the knee or the bottom way.
- While the set is not full, every victim is empty.

The bench scenarios cover the choices that depend on order:
- that the victim is the nearest qualifying way rather than just any qualifying way;
- that ways below a refilled way keep their flags;
- that flags clear when their ways move;
- that the escape threshold overrides the knee search.

// File: rtl/fsv_pkg.sv
package fsv_pkg;
    typedef enum logic {
        ST_WARM = 1'b0,
        ST_FULL = 1'b1
    } fsv_state_e;
endpackage

// File: rtl/fsv_lfsr.sv
module fsv_lfsr #(
    parameter int          W     = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = {1'b0, value[W-1:1]};
        if (value[0]) nxt = nxt ^ TAPS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) value <= SEED;
        else        value <= nxt;
    end
endmodule

// File: rtl/fsv_fill_stack.sv
module fsv_fill_stack #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_valid,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic                        hit_valid,
    input  logic [WAY_W-1:0]            hit_way,
    output logic [WAYS-1:0]             valid,
    output logic [WAYS-1:0][WAY_W-1:0]  pos,
    output logic [WAYS-1:0]             hitf
);
    logic [WAYS-1:0]            valid_d;
    logic [WAYS-1:0][WAY_W-1:0] pos_d;
    logic [WAYS-1:0]            hitf_d;
    logic                       old_valid;
    logic [WAY_W-1:0]           old_pos;

    assign old_valid = valid[fill_way];
    assign old_pos   = pos[fill_way];

    always_comb begin
        valid_d = valid;
        pos_d   = pos;
        hitf_d  = hitf;
        for (int i = 0; i < WAYS; i++) begin
            if (fill_valid && fill_way == WAY_W'(i)) begin
                valid_d[i] = 1'b1;
                pos_d[i]   = '0;
                hitf_d[i]  = 1'b0;
            end else if (fill_valid && valid[i] && (!old_valid || pos[i] < old_pos)) begin
                pos_d[i]  = pos[i] + 1'b1;
                hitf_d[i] = 1'b0;
            end else if (hit_valid && hit_way == WAY_W'(i) && valid[i]) begin
                hitf_d[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            pos   <= '0;
            hitf  <= '0;
        end else begin
            valid <= valid_d;
            pos   <= pos_d;
            hitf  <= hitf_d;
        end
    end
endmodule

// File: rtl/fsv_pick.sv
module fsv_pick #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][WAY_W-1:0] pos,
    input  logic [WAYS-1:0]            hitf,
    input  logic [WAY_W-1:0]           knee,
    output logic [WAY_W-1:0]           empty_way,
    output logic                       cand_found,
    output logic [WAY_W-1:0]           cand_way,
    output logic [WAY_W-1:0]           bottom_way
);
    localparam logic [WAY_W-1:0] BOTTOM = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] best_pos;

    always_comb begin
        empty_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) empty_way = WAY_W'(i);
        end
    end

    always_comb begin
        cand_found = 1'b0;
        cand_way   = '0;
        best_pos   = '1;
        for (int i = 0; i < WAYS; i++) begin
            if (valid[i] && pos[i] < knee && !hitf[i] &&
                (!cand_found || pos[i] < best_pos)) begin
                cand_found = 1'b1;
                cand_way   = WAY_W'(i);
                best_pos   = pos[i];
            end
        end
    end

    always_comb begin
        bottom_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (valid[i] && pos[i] == BOTTOM) bottom_way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/fill_stack_victim_sel.sv
module fill_stack_victim_sel
    import fsv_pkg::*;
#(
    parameter int          WAYS    = 8,
    parameter int          LFSR_W  = 16,
    parameter logic [15:0] LFSR_TAPS = 16'hB400,
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    localparam int         WAY_W   = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic              hit_valid,
    input  logic [WAY_W-1:0]  hit_way,
    input  logic              victim_req,
    input  logic [WAY_W-1:0]  knee,
    input  logic [LFSR_W-1:0] escape_thresh,
    output logic              victim_valid,
    output logic [WAY_W-1:0]  victim_way
);
    fsv_state_e                 state, state_nxt;
    logic [WAYS-1:0]            valid;
    logic [WAYS-1:0][WAY_W-1:0] pos;
    logic [WAYS-1:0]            hitf;
    logic [WAY_W-1:0]           empty_way, cand_way, bottom_way;
    logic                       cand_found;
    logic [LFSR_W-1:0]          rnd;
    logic                       escape;
    logic [WAYS-1:0]            fill_mask;

    fsv_fill_stack #(.WAYS(WAYS), .WAY_W(WAY_W)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_way(fill_way),
        .hit_valid(hit_valid), .hit_way(hit_way),
        .valid(valid), .pos(pos), .hitf(hitf)
    );

    fsv_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .valid(valid), .pos(pos), .hitf(hitf), .knee(knee),
        .empty_way(empty_way), .cand_found(cand_found),
        .cand_way(cand_way), .bottom_way(bottom_way)
    );

    fsv_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS[LFSR_W-1:0]), .SEED(LFSR_SEED[LFSR_W-1:0])) u_lfsr (
        .clk(clk), .rst_n(rst_n), .value(rnd)
    );

    assign escape    = (rnd <= escape_thresh);
    assign fill_mask = fill_valid ? (WAYS'(1) << fill_way) : '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WARM;
        else        state <= state_nxt;
    end

    // transitions: T_SET_FULL moves ST_WARM to ST_FULL
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WARM: if (&(valid | fill_mask)) state_nxt = ST_FULL;
            ST_FULL: state_nxt = ST_FULL;
            default: state_nxt = ST_WARM;
        endcase
    end

    // outputs
    always_comb begin
        victim_valid = victim_req;
        victim_way   = '0;
        unique case (state)
            ST_WARM: victim_way = empty_way;
            ST_FULL: victim_way = (cand_found && !escape) ? cand_way : bottom_way;
            default: victim_way = '0;
        endcase
    end
endmodule

// File: rtl/fsv_checker.sv
module fsv_checker #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        fill_valid,
    input logic [WAY_W-1:0]            fill_way,
    input logic                        hit_valid,
    input logic [WAY_W-1:0]            hit_way,
    input logic                        victim_req,
    input logic [WAY_W-1:0]            knee,
    input logic [WAY_W-1:0]            victim_way,
    input logic [WAYS-1:0]             valid,
    input logic [WAYS-1:0][WAY_W-1:0]  pos,
    input logic [WAYS-1:0]             hitf
);
    logic [WAYS-1:0] occ;
    always_comb begin
        occ = '0;
        for (int i = 0; i < WAYS; i++) if (valid[i]) occ[pos[i]] = 1'b1;
    end

    // R2
    warm_pick_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_req && !(&valid) |-> !valid[victim_way]);

    // R3
    fill_to_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> valid[$past(fill_way)] && pos[$past(fill_way)] == '0);

    // R3
    distinct_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(occ) == $countones(valid));

    // R5
    hit_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && !fill_valid && valid[hit_way] |=> hitf[$past(hit_way)]);

    // R11
    fill_beats_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && hit_valid && hit_way == fill_way |=> !hitf[$past(fill_way)]);

    // R12
    stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &valid |=> &valid);

    // R6 R7
    full_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_req && &valid |->
            (pos[victim_way] < knee && !hitf[victim_way]) ||
            pos[victim_way] == WAY_W'(WAYS - 1));

    // R8
    knee_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_req && &valid && knee == '0 |-> pos[victim_way] == WAY_W'(WAYS - 1));
endmodule

bind fill_stack_victim_sel fsv_checker #(.WAYS(WAYS), .WAY_W(WAY_W)) u_fsv_checker (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_way(fill_way),
    .hit_valid(hit_valid), .hit_way(hit_way),
    .victim_req(victim_req), .knee(knee), .victim_way(victim_way),
    .valid(valid), .pos(pos), .hitf(hitf)
);

// File: tb/test_fill_stack_victim_sel.sv
`timescale 1ns/1ps
module test_fill_stack_victim_sel;
    typedef struct packed {
        logic        fill;
        logic [2:0]  fway;
        logic        hit;
        logic [2:0]  hway;
        logic        req;
        logic [2:0]  knee;
        logic [15:0] thr;
        logic [2:0]  exp;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd7,16'h0000,3'd0,8'd2},  // R2 empty set
        '{1'b1,3'd0,1'b0,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd7,16'h0000,3'd1,8'd2},  // R2
        '{1'b1,3'd3,1'b0,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd7,16'h0000,3'd1,8'd2},  // R2
        '{1'b1,3'd1,1'b0,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd7,16'h0000,3'd2,8'd2},  // R2
        '{1'b1,3'd2,1'b0,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b1,3'd4,1'b0,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b1,3'd5,1'b0,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b1,3'd6,1'b0,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd7,16'h0000,3'd7,8'd2},  // R2 last empty
        '{1'b1,3'd7,1'b0,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd7,16'h0000,3'd7,8'd6},  // R6 top unhit
        '{1'b0,3'd0,1'b1,3'd7,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd7,16'h0000,3'd6,8'd5},  // R5 hit skips top
        '{1'b0,3'd0,1'b1,3'd6,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b1,3'd5,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd3,16'h0000,3'd0,8'd7},  // R7 none qualifies
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd4,16'h0000,3'd4,8'd6},  // R6 knee 4
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd0,16'h0000,3'd0,8'd8},  // R8 knee 0
        '{1'b1,3'd0,1'b0,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd3,16'h0000,3'd0,8'd3},  // R3 refill at top
        '{1'b0,3'd0,1'b1,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd3,16'h0000,3'd7,8'd4},  // R4 moved flag cleared
        '{1'b0,3'd0,1'b1,3'd4,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b1,3'd5,1'b0,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b1,3'd5,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b1,3'd0,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b1,3'd7,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b1,3'd6,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd7,16'h0000,3'd2,8'd3},  // R3 lower way kept flag
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd7,16'hFFFF,3'd3,8'd9},  // R9 forced escape
        '{1'b1,3'd1,1'b1,3'd1,1'b0,3'd7,16'h0000,3'd0,8'd0},
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd7,16'h0000,3'd1,8'd11}, // R11 fill wins
        '{1'b0,3'd0,1'b0,3'd0,1'b1,3'd0,16'h0000,3'd3,8'd12}  // R12 still full
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_valid = 1'b0, hit_valid = 1'b0, victim_req = 1'b0;
    logic [2:0]  fill_way = '0, hit_way = '0, knee = '0;
    logic [15:0] escape_thresh = '0;
    logic        victim_valid;
    logic [2:0]  victim_way;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    fill_stack_victim_sel i_fill_stack_victim_sel (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_way(fill_way),
        .hit_valid(hit_valid), .hit_way(hit_way),
        .victim_req(victim_req), .knee(knee), .escape_thresh(escape_thresh),
        .victim_valid(victim_valid), .victim_way(victim_way)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        fill_valid = 1'b0; hit_valid = 1'b0; victim_req = 1'b0;
        fill_way = '0; hit_way = '0; knee = 3'd7; escape_thresh = '0;
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1 check("R10 valid low without request", int'(victim_valid), 0);
        @(negedge clk) victim_req = 1'b1;
        #1 check("R1 reset victim", int'(victim_way), 0);
        check("R10 valid with request", int'(victim_valid), 1);
        @(negedge clk) idle();

        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            fill_valid = VEC[n].fill; fill_way = VEC[n].fway;
            hit_valid = VEC[n].hit;   hit_way = VEC[n].hway;
            victim_req = VEC[n].req;  knee = VEC[n].knee;
            escape_thresh = VEC[n].thr;
            #1;
            if (VEC[n].req)
                check($sformatf("R%0d vector %0d", VEC[n].tag, n), int'(victim_way), int'(VEC[n].exp));
        end
        @(negedge clk) idle();

        // R9 repeated forced escape over several generator steps
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            victim_req = 1'b1; knee = 3'd7; escape_thresh = 16'hFFFF;
            #1 check("R9 escape every cycle", int'(victim_way), 3);
        end
        // R9 threshold zero never escapes: top way 1 is unhit
        @(negedge clk) escape_thresh = 16'h0000;
        #1 check("R9 no escape at zero", int'(victim_way), 1);

        // R1 reset mid-run empties the set
        @(negedge clk) begin idle(); rst_n = 1'b0; end
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) victim_req = 1'b1;
        #1 check("R1 victim after second reset", int'(victim_way), 0);
        @(negedge clk) fill_valid = 1'b1; fill_way = 3'd0; victim_req = 1'b0;
        @(negedge clk) begin fill_valid = 1'b0; victim_req = 1'b1; end
        #1 check("R2 next empty after reset", int'(victim_way), 1);
        @(negedge clk) idle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule